// File: doc/BRIEF.md
# Parallel EEPROM Device-Side Port

This block takes the device side of a byte-wide parallel EEPROM bus. Three active-low control pins (chip select, output enable, write strobe) come from a host that has no clock of its own. A fast system clock samples them, and edge detection finds where each read and write cycle starts and ends. Behind the pins sits a storage array of 2^ADDR_W bytes. A full part would be 32K x 8, with ADDR_W = 15. The default is smaller so that elaboration stays light.

A write goes into a page buffer first. The address is taken when the later of chip select or write strobe falls. The data is taken when the earlier of the two rises. Bytes are collected until the host stays quiet for a set number of clocks. A timed programming phase follows, and then one pass copies the buffered bytes into the array. No host action is needed to finish. While this runs, reads return a status pattern that lets the host poll for completion.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain levels. The host must space its pin edges by a few system clocks.

Top module: `ee_par_port`

## Requirements
- R1: `dout_en` is high only while chip select and output enable are both seen low; this is seen within 3 clocks of the pin change. `dout` is zero whenever `dout_en` is low.
- R2: When no write is pending, a read returns the byte stored at `addr`.
- R3: The write address is taken on the later falling edge of chip select or write strobe. This holds for both strobe-controlled and select-controlled cycles. Address changes after that edge have no effect.
- R4: Write data is taken on the earlier rising edge of chip select or write strobe. Data changes after that edge have no effect.
- R5: A strobe pulse while output enable is low starts no write. The block does not go busy, and the array keeps its contents.
- R6: One programming cycle commits up to 64 bytes that share the same page. A page is the set of `addr` bits from bit 6 upward, and `addr[5:0]` selects the byte within the page.
- R7: A write to a different page while bytes are loading is ignored.
- R8: Loading ends after LOAD_WIN clocks with no accepted byte. A byte that arrives before that window runs out joins the page. Programming then lasts PROG_CYC clocks, followed by one commit pass.
- R9: While busy (loading, programming or committing), reads return three fields. Bit 7 is the complement of bit 7 of the last accepted byte. Bit 6 is a toggle that is 0 on the first busy read and flips at the end of every read. Bits 5:0 are zero.
- R10: Writes issued during programming are ignored. The array changes only in the commit pass.
- R11: A single byte write completes with no further host action. Afterwards, reads return the true data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data from host |
| dout | output | 8 | Data to host, zero when not driving |
| dout_en | output | 1 | High when the host bus should be driven |

## Verification
The assertions assume three things about the host. Its pin edges are far enough apart that each one settles through the synchronizer before the next arrives. Address and data are steady at the sample where a control edge is seen. Output enable stays still for the length of a write cycle.

The stimulus meets these conditions. It moves every pin on the falling clock edge and holds each level for at least three clocks. It changes address or data only some clocks after the edge that captured them. It never toggles output enable inside a write, except in the deliberate output-enable-low case.

// File: rtl/ee_pkg.sv
`timescale 1ns/1ps
package ee_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_COMMIT = 2'd3
  } ee_state_t;
endpackage

// File: rtl/ee_pin_edges.sv
`timescale 1ns/1ps
// Synchronizes the asynchronous host pins and finds cycle boundaries.
module ee_pin_edges #(
  parameter int AW   = 11,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_din,
  output logic          s_ce_n,
  output logic          s_oe_n,
  output logic          rd_act,
  output logic          rd_end,
  output logic          wr_start,
  output logic          wr_end
);
  localparam int BW = 3 + AW + DW;
  localparam logic [BW-1:0] IDLE_WORD = {3'b111, {(AW+DW){1'b0}}};

  logic [SYNC-1:0][BW-1:0] pipe;
  logic [BW-1:0]           tail;
  logic                    s_we_n, wr_act, rd_q, wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {SYNC{IDLE_WORD}};
    else        pipe <= {pipe[SYNC-2:0], {ce_n, oe_n, we_n, addr, din}};
  end

  assign tail = pipe[SYNC-1];
  assign {s_ce_n, s_oe_n, s_we_n, s_addr, s_din} = tail;

  assign rd_act = !s_ce_n && !s_oe_n;
  assign wr_act = !s_ce_n && !s_we_n && s_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign rd_end   = rd_q && !rd_act;
  assign wr_start = wr_act && !wr_q;
  assign wr_end   = wr_q && !wr_act;
endmodule

// File: rtl/ee_page_buf.sv
`timescale 1ns/1ps
// One page of staged bytes with a per-byte valid mask.
module ee_page_buf #(
  parameter int PW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int PAGE = 1 << PW;

  logic [DW-1:0]   bytes_q [PAGE];
  logic [PAGE-1:0] mask;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mask[g] <= 1'b0;
      else if (wr_en && (wr_idx == PW'(g)))         mask[g] <= 1'b1;
      else if (clr)                                 mask[g] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PW'(g))) bytes_q[g] <= wr_data;
    end
  end

  assign rd_data  = bytes_q[rd_idx];
  assign rd_valid = mask[rd_idx];
endmodule

// File: rtl/ee_prog_fsm.sv
`timescale 1ns/1ps
// Load window, programming timer and byte-serial commit sequencing.
module ee_prog_fsm
  import ee_pkg::*;
#(
  parameter int PW       = 6,
  parameter int LOAD_WIN = 64,
  parameter int PROG_CYC = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_evt,
  input  logic          same_page,
  output ee_state_t     st,
  output logic          accept,
  output logic          tag_we,
  output logic          buf_clr,
  output logic          commit_go,
  output logic [PW-1:0] commit_idx
);
  localparam int CMAX = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    tag_we    = byte_evt && (st == ST_IDLE);
    accept    = tag_we || (byte_evt && (st == ST_LOAD) && same_page);
    commit_go = (st == ST_COMMIT);
    buf_clr   = commit_go && (&commit_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      commit_idx <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (byte_evt) begin
            st  <= ST_LOAD;
            cnt <= '0;
          end
        end
        ST_LOAD: begin
          if (accept) cnt <= '0;
          else if (cnt == CW'(LOAD_WIN - 1)) begin
            st  <= ST_PROG;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_PROG: begin
          if (cnt == CW'(PROG_CYC - 1)) begin
            st         <= ST_COMMIT;
            cnt        <= '0;
            commit_idx <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_COMMIT: begin
          commit_idx <= commit_idx + 1'b1;
          if (&commit_idx) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ee_par_port.sv
`timescale 1ns/1ps
// Device-side parallel EEPROM port with page buffer and self-timed commit.
module ee_par_port
  import ee_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 6,
  parameter int LOAD_WIN = 64,
  parameter int PROG_CYC = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int DW    = 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] s_addr, wr_addr;
  logic [DW-1:0]     s_din, buf_rd;
  logic              s_ce_n, s_oe_n, rd_act, rd_end, wr_start, wr_end;
  ee_state_t         st;
  logic              accept, tag_we, buf_clr, commit_go, buf_vld, mem_we;
  logic [PAGE_W-1:0] commit_idx;
  logic [TW-1:0]     tag;
  logic              same_page, busy, last_msb, tog;
  logic [DW-1:0]     mem [DEPTH];

  ee_pin_edges #(.AW(ADDR_W), .DW(DW), .SYNC(2)) u_pins (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .s_addr(s_addr), .s_din(s_din),
    .s_ce_n(s_ce_n), .s_oe_n(s_oe_n), .rd_act(rd_act), .rd_end(rd_end),
    .wr_start(wr_start), .wr_end(wr_end)
  );

  ee_prog_fsm #(.PW(PAGE_W), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .byte_evt(wr_end), .same_page(same_page),
    .st(st), .accept(accept), .tag_we(tag_we), .buf_clr(buf_clr),
    .commit_go(commit_go), .commit_idx(commit_idx)
  );

  ee_page_buf #(.PW(PAGE_W), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(accept),
    .wr_idx(wr_addr[PAGE_W-1:0]), .wr_data(s_din),
    .rd_idx(commit_idx), .rd_data(buf_rd), .rd_valid(buf_vld)
  );

  assign same_page = (wr_addr[ADDR_W-1:PAGE_W] == tag);
  assign busy      = (st != ST_IDLE);
  assign mem_we    = commit_go && buf_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr  <= '0;
      tag      <= '0;
      last_msb <= 1'b0;
      tog      <= 1'b0;
    end else begin
      if (wr_start) wr_addr  <= s_addr;
      if (tag_we)   tag      <= wr_addr[ADDR_W-1:PAGE_W];
      if (accept)   last_msb <= s_din[DW-1];
      if (!busy)        tog <= 1'b0;
      else if (rd_end)  tog <= ~tog;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[{tag, commit_idx}] <= buf_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_act;
      if (!rd_act)   dout <= '0;
      else if (busy) dout <= {~last_msb, tog, {(DW-2){1'b0}}};
      else           dout <= mem[s_addr];
    end
  end
endmodule

// File: rtl/ee_par_port_chk.sv
`timescale 1ns/1ps
module ee_par_port_chk
  import ee_pkg::*;
#(
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ce_n,
  input logic          s_oe_n,
  input logic          dout_en,
  input ee_state_t     st,
  input logic          accept,
  input logic          mem_we,
  input logic          rd_end,
  input logic          tog,
  input logic [TW-1:0] tag
);
  p_drive_needs_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(!s_ce_n && !s_oe_n));

  p_no_load_in_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG || st == ST_COMMIT) |-> !accept);

  p_array_write_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (st == ST_COMMIT));

  p_poll_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && rd_end) |=> (tog != $past(tog)));

  p_tag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(tag));
endmodule

bind ee_par_port ee_par_port_chk #(.TW(ADDR_W - PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ce_n(s_ce_n), .s_oe_n(s_oe_n),
  .dout_en(dout_en), .st(st), .accept(accept), .mem_we(mem_we),
  .rd_end(rd_end), .tog(tog), .tag(tag)
);

// File: tb/sim_ee_par_port.sv
`timescale 1ns/1ps
module sim_ee_par_port;
  localparam int AW   = 11;
  localparam int PW   = 6;
  localparam int LWIN = 64;
  localparam int PCYC = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ee_par_port #(.ADDR_W(AW), .PAGE_W(PW), .LOAD_WIN(LWIN), .PROG_CYC(PCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wait_done();
    tick(LWIN + PCYC + (1 << PW) + 40);
  endtask

  // strobe-controlled: chip select falls first, strobe falls last and rises first
  task automatic wr_we(input logic [AW-1:0] a, input logic [7:0] d);
    tick(1);
    oe_n = 1'b1; ce_n = 1'b0; addr = a; din = d;
    tick(3); we_n = 1'b0;
    tick(4); addr = a ^ 11'h2A5;
    tick(3); we_n = 1'b1;
    tick(4); din = ~d; ce_n = 1'b1;
    tick(4);
  endtask

  // select-controlled: strobe falls first, chip select falls last and rises first
  task automatic wr_ce(input logic [AW-1:0] a, input logic [7:0] d);
    tick(1);
    oe_n = 1'b1; we_n = 1'b0; addr = a; din = d;
    tick(3); ce_n = 1'b0;
    tick(4); addr = a ^ 11'h2A5;
    tick(3); ce_n = 1'b1;
    tick(4); din = ~d;
    tick(3); we_n = 1'b1;
    tick(4);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic en);
    tick(1);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    tick(6);
    v = dout; en = dout_en;
    oe_n = 1'b1; ce_n = 1'b1;
    tick(5);
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 reset dout_en", {7'd0, dout_en}, 8'h00);
    chk("R1 reset dout", dout, 8'h00);
  endtask

  task automatic t_single_byte();
    logic [7:0] v; logic en;
    wr_we(11'h012, 8'hA5);
    rd(11'h012, v, en);
    chk("R1 drive during read", {7'd0, en}, 8'h01);
    chk("R9 first busy read", v, 8'h00);
    rd(11'h012, v, en);
    chk("R9 second busy read toggles", v, 8'h40);
    chk("R1 released after read", {7'd0, dout_en}, 8'h00);
    chk("R1 dout zero when idle", dout, 8'h00);
    wait_done();
    rd(11'h012, v, en);
    chk("R11 R3 true data after commit", v, 8'hA5);
    rd(11'h012 ^ 11'h2A5, v, en);
    n_chk++;
    if (v === 8'hA5 && en) begin
      n_fail++;
      $display("FAIL R3: late address took the byte, got %02h expected not a5", v);
    end
  endtask

  task automatic t_select_write();
    logic [7:0] v; logic en;
    wr_ce(11'h081, 8'h3C);
    wait_done();
    rd(11'h081, v, en);
    chk("R4 R3 select-controlled byte", v, 8'h3C);
    wr_we(11'h300, 8'h11);
    wait_done();
    rd(11'h300, v, en);
    chk("R2 idle read", v, 8'h11);
  endtask

  task automatic t_oe_low_write();
    logic [7:0] v; logic en;
    tick(1);
    addr = 11'h012; din = 8'h00; ce_n = 1'b0; oe_n = 1'b0;
    tick(3); we_n = 1'b0;
    tick(4); we_n = 1'b1;
    tick(3); oe_n = 1'b1; ce_n = 1'b1;
    tick(4);
    rd(11'h012, v, en);
    chk("R5 no busy and data kept", v, 8'hA5);
    wait_done();
    rd(11'h012, v, en);
    chk("R5 data kept later", v, 8'hA5);
  endtask

  task automatic t_page();
    logic [7:0] v; logic en;
    for (int i = 0; i < 64; i++) begin
      wr_we(11'h040 + 11'(i), 8'(i * 3 + 1));
      if (i == 10) wr_we(11'h300, 8'hEE);
    end
    wait_done();
    rd(11'h040, v, en); chk("R6 page first byte", v, 8'h01);
    rd(11'h04A, v, en); chk("R6 page middle byte", v, 8'h1F);
    rd(11'h07F, v, en); chk("R6 page last byte", v, 8'hBE);
    rd(11'h300, v, en); chk("R7 foreign page ignored", v, 8'h11);
  endtask

  task automatic t_window_and_prog();
    logic [7:0] v; logic en;
    wr_we(11'h0C0, 8'h21);
    tick(LWIN - 40);
    wr_we(11'h0C1, 8'h22);
    tick(LWIN + 20);
    rd(11'h0C0, v, en);
    chk("R9 busy poll fields", v & 8'hBF, 8'h80);
    wr_we(11'h0C0, 8'h99);
    wait_done();
    rd(11'h0C0, v, en); chk("R10 write during programming ignored", v, 8'h21);
    rd(11'h0C1, v, en); chk("R8 byte inside window joined page", v, 8'h22);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    t_reset();
    t_single_byte();
    t_select_write();
    t_oe_low_write();
    t_page();
    t_window_and_prog();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule